// File: doc/BRIEF.md
# ECC Error Logging Register File

This block sits beside a DRAM ECC checker and records the errors that the checker reports. The checker drives a one-cycle pulse for a correctable error or for an uncorrectable error. With each pulse it presents the failing physical address, an 8-bit syndrome and a one-bit channel number. The block keeps one error record, made of a block address, a syndrome and a channel, together with two sticky status flags. Software reads these through a small word-addressed register port.

The record gives priority to the more serious event. An uncorrectable error takes over a record that holds only a correctable error. A correctable error never replaces an uncorrectable record. A further event of a kind that is already flagged leaves the record alone, so the first failure is kept until software acknowledges it. Software acknowledges a flag by writing 1 to its bit.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every mapped register reads zero.
- R2: A correctable pulse (`ce_i`) sets status bit 0. When no flag is set, it also records the address, syndrome and channel presented with it.
- R3: An uncorrectable pulse (`ue_i`) sets status bit 7 and records the address, syndrome and channel, unless bit 7 was already set.
- R4: The address register (offset 0x04) returns the recorded address with bits 11:0 forced to zero, giving 4 KiB granularity. The syndrome register (offset 0x08) returns the syndrome in bits 7:0. The channel register (offset 0x0C) returns the channel in bit 0.
- R5: A write to the status register (offset 0x00) clears bit 0 when data bit 0 is 1 and clears bit 7 when data bit 7 is 1. A 0 in either data bit leaves that flag unchanged.
- R6: An uncorrectable error that arrives while only bit 0 is set replaces the record and leaves status at 0x0081. A correctable and an uncorrectable pulse arriving in the same cycle record the uncorrectable information.
- R7: A correctable pulse while bit 7 is set sets bit 0 and does not change the address, syndrome or channel.
- R8: A second event of a kind whose flag is already set does not change the record.
- R9: If an event and a write-1 clear of the same flag fall in the same cycle, the flag stays set.
- R10: Offsets other than 0x00, 0x04, 0x08 and 0x0C read zero, and writes to them change nothing. Writes to the address, syndrome and channel registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Correctable-error pulse from the ECC checker |
| ue_i | input | 1 | Uncorrectable-error pulse from the ECC checker |
| err_addr_i | input | 32 | Failing physical address |
| err_syn_i | input | 8 | ECC syndrome of the failing access |
| err_chan_i | input | 1 | Channel of the failing access |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |

## Verification
The bench drives single correctable and uncorrectable pulses into an empty log, which shows whether each event type sets its own flag and records its data. It then drives pairs of events in both orders and of the same kind. These separate the uncorrectable takeover from the rule that a correctable error never displaces anything, and show that the first error is held. Clears are written with bits at 1, bits at 0, and at the same time as a new event, which tells a true write-1-to-clear apart from a plain write and shows which side wins a tie. Writes with all bits set go to unmapped and read-only offsets, and the bench then reads the log back to confirm it did not change.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int unsigned CE_BIT = 0;
  localparam int unsigned UE_BIT = 7;
  localparam int unsigned STAT_W = 16;

  localparam logic [4:0] OFF_STAT = 5'h00;
  localparam logic [4:0] OFF_ADDR = 5'h04;
  localparam logic [4:0] OFF_SYN  = 5'h08;
  localparam logic [4:0] OFF_CHAN = 5'h0C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_ADDR, SEL_SYN, SEL_CHAN
  } reg_sel_e;
endpackage

// File: rtl/ecc_log_core.sv
module ecc_log_core #(
  parameter int unsigned BLK_W = 20,
  parameter int unsigned SYN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             ue_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [SYN_W-1:0] syn_i,
  input  logic             chan_i,
  input  logic             clr_ce_i,
  input  logic             clr_ue_i,
  output logic             ce_q_o,
  output logic             ue_q_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [SYN_W-1:0] syn_o,
  output logic             chan_o
);
  logic             ce_q, ue_q, chan_q;
  logic [BLK_W-1:0] blk_q;
  logic [SYN_W-1:0] syn_q;
  logic             load_ue, load_ce, load;

  // UE may replace a CE record; CE only loads into an empty log
  assign load_ue = ue_i & ~ue_q;
  assign load_ce = ce_i & ~ce_q & ~ue_q & ~ue_i;
  assign load    = load_ue | load_ce;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b0;
      ue_q   <= 1'b0;
      blk_q  <= '0;
      syn_q  <= '0;
      chan_q <= 1'b0;
    end else begin
      ce_q <= ce_i | (ce_q & ~clr_ce_i);
      ue_q <= ue_i | (ue_q & ~clr_ue_i);
      if (load) begin
        blk_q  <= blk_i;
        syn_q  <= syn_i;
        chan_q <= chan_i;
      end
    end
  end

  assign ce_q_o = ce_q;
  assign ue_q_o = ue_q;
  assign blk_o  = blk_q;
  assign syn_o  = syn_q;
  assign chan_o = chan_q;

  // R2
  ce_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> ce_q_o);
  // R3
  ue_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_i |=> ue_q_o);
  // R5
  ce_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ce_i && !ce_i) |=> !ce_q_o);
  // R5
  ue_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ue_i && !ue_i) |=> !ue_q_o);
  // R7
  ue_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_q_o |=> ($stable(blk_o) && $stable(syn_o) && $stable(chan_o)));
  // R6
  ue_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_i && !ue_q_o) |=> (blk_o == $past(blk_i) && syn_o == $past(syn_i)));
  // R9
  race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && clr_ce_i) |=> ce_q_o);
endmodule

// File: rtl/ecc_log_regif.sv
module ecc_log_regif
  import ecc_log_pkg::*;
#(
  parameter int unsigned PA_W    = 32,
  parameter int unsigned BLK_LSB = 12,
  parameter int unsigned SYN_W   = 8,
  parameter int unsigned OFF_W   = 5,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned BLK_W  = PA_W - BLK_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFF_W-1:0]  reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              ce_q_i,
  input  logic              ue_q_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [SYN_W-1:0]  syn_i,
  input  logic              chan_i,
  output logic              clr_ce_o,
  output logic              clr_ue_o,
  output logic [DATA_W-1:0] reg_rdata_o
);
  reg_sel_e          sel;
  logic [STAT_W-1:0] stat;
  logic              wr_stat;

  always_comb begin
    sel = SEL_NONE;
    if      (reg_addr_i == OFF_STAT[OFF_W-1:0]) sel = SEL_STAT;
    else if (reg_addr_i == OFF_ADDR[OFF_W-1:0]) sel = SEL_ADDR;
    else if (reg_addr_i == OFF_SYN[OFF_W-1:0])  sel = SEL_SYN;
    else if (reg_addr_i == OFF_CHAN[OFF_W-1:0]) sel = SEL_CHAN;
  end

  always_comb begin
    stat         = '0;
    stat[CE_BIT] = ce_q_i;
    stat[UE_BIT] = ue_q_i;
  end

  assign wr_stat  = reg_wr_i && (sel == SEL_STAT);
  assign clr_ce_o = wr_stat & reg_wdata_i[CE_BIT];
  assign clr_ue_o = wr_stat & reg_wdata_i[UE_BIT];

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_STAT: reg_rdata_o[STAT_W-1:0]  = stat;
      SEL_ADDR: reg_rdata_o[PA_W-1:0]    = {blk_i, {BLK_LSB{1'b0}}};
      SEL_SYN:  reg_rdata_o[SYN_W-1:0]   = syn_i;
      SEL_CHAN: reg_rdata_o[0]           = chan_i;
      default:  reg_rdata_o              = '0;
    endcase
  end

  // R4
  addr_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFF_ADDR[OFF_W-1:0]) |-> (reg_rdata_o[BLK_LSB-1:0] == '0));
  // R10
  unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[1:0] != 2'b00 || reg_addr_i > OFF_CHAN[OFF_W-1:0])
      |-> (reg_rdata_o == '0 && !clr_ce_o && !clr_ue_o));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int unsigned PA_W    = 32,
  parameter int unsigned BLK_LSB = 12,
  parameter int unsigned SYN_W   = 8,
  parameter int unsigned OFF_W   = 5,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              ue_i,
  input  logic [PA_W-1:0]   err_addr_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic              err_chan_i,
  input  logic [OFF_W-1:0]  reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int unsigned BLK_W = PA_W - BLK_LSB;

  logic             ce_q, ue_q, chan_q, clr_ce, clr_ue;
  logic [BLK_W-1:0] blk_q;
  logic [SYN_W-1:0] syn_q;
  logic             unused_low;

  assign unused_low = ^err_addr_i[BLK_LSB-1:0];

  ecc_log_core #(.BLK_W(BLK_W), .SYN_W(SYN_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce_i),
    .ue_i    (ue_i),
    .blk_i   (err_addr_i[PA_W-1:BLK_LSB]),
    .syn_i   (err_syn_i),
    .chan_i  (err_chan_i),
    .clr_ce_i(clr_ce),
    .clr_ue_i(clr_ue),
    .ce_q_o  (ce_q),
    .ue_q_o  (ue_q),
    .blk_o   (blk_q),
    .syn_o   (syn_q),
    .chan_o  (chan_q)
  );

  ecc_log_regif #(
    .PA_W(PA_W), .BLK_LSB(BLK_LSB), .SYN_W(SYN_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_wdata_i(reg_wdata_i),
    .ce_q_i     (ce_q),
    .ue_q_i     (ue_q),
    .blk_i      (blk_q),
    .syn_i      (syn_q),
    .chan_i     (chan_q),
    .clr_ce_o   (clr_ce),
    .clr_ue_o   (clr_ue),
    .reg_rdata_o(reg_rdata_o)
  );
endmodule

// File: tb/ecc_err_log_test.sv
module ecc_err_log_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ce_i = 1'b0, ue_i = 1'b0, err_chan_i = 1'b0, reg_wr_i = 1'b0;
  logic [31:0] err_addr_i = '0, reg_wdata_i = '0, reg_rdata_o;
  logic [7:0]  err_syn_i = '0;
  logic [4:0]  reg_addr_i = '0;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  ecc_err_log uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .ue_i(ue_i),
    .err_addr_i(err_addr_i), .err_syn_i(err_syn_i), .err_chan_i(err_chan_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] off, output logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = off;
    #1 v = reg_rdata_o;
  endtask

  task automatic wr(input logic [4:0] off, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = off; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic ev(input bit ce, input bit ue, input logic [31:0] a,
                    input logic [7:0] s, input bit c);
    @(negedge clk_i);
    ce_i = ce; ue_i = ue; err_addr_i = a; err_syn_i = s; err_chan_i = c;
    @(negedge clk_i);
    ce_i = 1'b0; ue_i = 1'b0;
  endtask

  task automatic chk_log(string req, logic [31:0] st, logic [31:0] a,
                         logic [7:0] s, bit c);
    logic [31:0] v;
    rd(5'h00, v); chk({req, " status"}, v, st);
    rd(5'h04, v); chk({req, " addr"}, v, a);
    rd(5'h08, v); chk({req, " syn"}, v, {24'h0, s});
    rd(5'h0C, v); chk({req, " chan"}, v, {31'h0, c});
  endtask

  task automatic t_reset();
    chk_log("R1 reset", 32'h0, 32'h0, 8'h00, 1'b0);
  endtask

  task automatic t_ce_log();
    ev(1, 0, 32'h1234_5ABC, 8'h3C, 1);
    chk_log("R2 R4 ce log", 32'h0001, 32'h1234_5000, 8'h3C, 1'b1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(5'h00, 32'h0000_0000); rd(5'h00, v); chk("R5 write0 keeps", v, 32'h0001);
    wr(5'h00, 32'h0000_0080); rd(5'h00, v); chk("R5 other bit keeps", v, 32'h0001);
    wr(5'h00, 32'h0000_0001); rd(5'h00, v); chk("R5 w1c ce", v, 32'h0000);
  endtask

  task automatic t_ce_repeat();
    ev(1, 0, 32'hAAAA_1FFF, 8'h11, 0);
    ev(1, 0, 32'h5555_2000, 8'h22, 1);
    chk_log("R8 ce repeat", 32'h0001, 32'hAAAA_1000, 8'h11, 1'b0);
  endtask

  task automatic t_ue_over_ce();
    logic [31:0] v;
    ev(0, 1, 32'hDEAD_BEEF, 8'h99, 1);
    chk_log("R6 ue over ce", 32'h0081, 32'hDEAD_B000, 8'h99, 1'b1);
    wr(5'h00, 32'h0000_0001);
    ev(1, 0, 32'h0F0F_0F0F, 8'h44, 0);
    chk_log("R7 ce under ue", 32'h0081, 32'hDEAD_B000, 8'h99, 1'b1);
    wr(5'h00, 32'h0000_0080); rd(5'h00, v); chk("R5 w1c ue", v, 32'h0001);
    wr(5'h00, 32'h0000_0081); rd(5'h00, v); chk("R5 w1c both", v, 32'h0000);
  endtask

  task automatic t_ue_repeat();
    ev(0, 1, 32'h0000_3000, 8'h01, 0);
    ev(0, 1, 32'h7777_7000, 8'h02, 1);
    chk_log("R3 R8 ue repeat", 32'h0080, 32'h0000_3000, 8'h01, 1'b0);
    wr(5'h00, 32'h0000_0080);
    ev(1, 1, 32'h2468_ACE0, 8'h5A, 1);
    chk_log("R6 same-cycle ce ue", 32'h0081, 32'h2468_A000, 8'h5A, 1'b1);
    wr(5'h00, 32'h0000_0081);
  endtask

  task automatic t_race();
    logic [31:0] v;
    ev(1, 0, 32'h1111_1000, 8'h10, 0);
    @(negedge clk_i);
    reg_addr_i = 5'h00; reg_wdata_i = 32'h81; reg_wr_i = 1'b1; ce_i = 1'b1; ue_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0; ce_i = 1'b0; ue_i = 1'b0;
    rd(5'h00, v); chk("R9 event beats clear", v, 32'h0081);
    wr(5'h00, 32'h0000_0081); rd(5'h00, v); chk("R9 later clear", v, 32'h0000);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    ev(1, 0, 32'hCAFE_F00D, 8'h77, 1);
    wr(5'h02, 32'hFFFF_FFFF);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    chk_log("R10 writes ignored", 32'h0001, 32'hCAFE_F000, 8'h77, 1'b1);
    rd(5'h10, v); chk("R10 read 0x10", v, 32'h0);
    rd(5'h02, v); chk("R10 read 0x02", v, 32'h0);
    rd(5'h1C, v); chk("R10 read 0x1C", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ce_log();
    t_w1c();
    t_ce_repeat();
    t_ue_over_ce();
    t_ue_repeat();
    t_race();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule